// File: doc/BRIEF.md
# Mask-to-byte-strobe predication generator

This block turns beats of the mask register into per-lane byte write strobes for predicated vector instructions. Each beat holds `NLANES` 64-bit lane words. The mask register is stored in a lane-interleaved byte layout with a mask element width of 8, 16, 32 or 64 bits. The block first puts the beat's mask bits back into linear element order. It then picks the bit of each data element and widens it to the bytes that element covers at the current data element width. Elements at or beyond the vector length are switched off.

Every strobe set carries one 8-bit strobe per lane and goes into a small queue. The consuming units read the queue over a valid/ready handshake and stall while it is empty. One input beat can supply many strobe sets, up to one set per bit of the data element width. The beat is held until its last set has gone into the queue, and only then is it acknowledged. A start pulse begins each instruction. It captures the vector length and both width codes, and it clears the running element counter.

Top module: `mask_strobe_gen`

## Requirements
- R1: After reset, `strb_valid_o` is 0 and `mask_ready_o` is 1. A beat that arrives before any start pulse is taken and produces no strobes.
- R2: The mask width code `mew_i` selects a layout: 0 for 8 bits, 1 for 16, 2 for 32, 3 for 64 (MEW). Linear mask bit i sits in mask element k = i / MEW at bit i % MEW. Mask element k sits in lane k % NLANES, at slot (k / NLANES) % (64 / MEW) of beat (k / NLANES) / (64 / MEW). A slot occupies beat bits lane*64 + slot*MEW onward.
- R3: The data width code `sew_i` uses the same encoding (SEW). Set o covers the data elements e = o*N + q, where N = NLANES*64/SEW and 0 <= q < N. Element e drives strobe bits lane*8 + slot*SEW/8 through lane*8 + (slot+1)*SEW/8 - 1, with lane = q % NLANES and slot = q / NLANES. All of those bits equal mask bit e.
- R4: Every strobe bit that belongs to an element index at or above the captured vector length is 0.
- R5: An instruction with vector length VL produces exactly ceil(VL/N) strobe sets, in order. The block acknowledges an input beat in the cycle it pushes the last set taken from that beat. That set is either the SEW-th set of the beat or the set that reaches VL.
- R6: While the queue is full, the block neither acknowledges an input beat nor advances its element counter. No strobe set is lost.
- R7: A start pulse captures `vl_i`, `sew_i` and `mew_i` and sets the element counter back to 0. In the pulse cycle the block pushes nothing and acknowledges no beat.
- R8: Once the counter has reached VL, each further input beat is acknowledged in the cycle it is offered and produces no strobe set.
- R9: The queue hands out strobe sets in first-in first-out order. While `strb_valid_o` is 1 and `strb_ready_i` is 0, the output set is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts an instruction: captures the configuration, clears the element counter |
| vl_i | input | VL_W | Vector length in elements |
| sew_i | input | 2 | Data element width code (0:8, 1:16, 2:32, 3:64) |
| mew_i | input | 2 | Mask register layout width code (0:8, 1:16, 2:32, 3:64) |
| mask_valid_i | input | 1 | Mask beat valid |
| mask_data_i | input | NLANES*64 | Mask beat, lane l in bits l*64 and up |
| mask_ready_o | output | 1 | Mask beat acknowledged at this edge |
| strb_valid_o | output | 1 | Strobe set available |
| strb_data_o | output | NLANES*8 | Strobe set, lane l in bits l*8 and up |
| strb_ready_i | input | 1 | Consumer accepts the strobe set |

## Verification
The hardest state to reach from the ports is a full queue in the middle of a beat. The beat is still held and its remaining sets are blocked. The bench gets there by running an 8-bit element width, where a beat yields eight sets, while the consumer is held off. It then checks that the beat stays unacknowledged and that nothing is lost once the consumer resumes. The rest of the stimulus walks every combination of data width and mask width with random mask bits. It uses vector lengths that are not multiples of the lane count, ends the tail in the middle of a set, and offers extra beats after the vector length has been reached.

// File: rtl/mstrb_pkg.sv
package mstrb_pkg;

  localparam int unsigned LANE_BITS  = 64;
  localparam int unsigned LANE_BYTES = 8;

  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } ew_e;

  // log2 of the element width in bytes
  function automatic int unsigned ew_log_bytes(ew_e w);
    return int'(w);
  endfunction

  // element width in bits
  function automatic int unsigned ew_bits(ew_e w);
    return 8 << int'(w);
  endfunction

endpackage

// File: rtl/mstrb_deshuffle.sv
module mstrb_deshuffle
  import mstrb_pkg::*;
#(
  parameter int unsigned NLANES = 4
) (
  input  logic [NLANES*LANE_BITS-1:0] beat_i,
  input  ew_e                         mew_i,
  output logic [NLANES*LANE_BITS-1:0] lin_o
);

  localparam int unsigned BEAT_W   = NLANES * LANE_BITS;
  localparam int unsigned IDX_W    = $clog2(BEAT_W);
  localparam int unsigned LANE_LOG = $clog2(NLANES);

  // position in the beat of linear mask bit i for a given layout width
  function automatic logic [IDX_W-1:0] src_pos(int unsigned i, ew_e mew);
    int unsigned mlog, k, b, lane, slot;
    mlog = 3 + ew_log_bytes(mew);
    k    = i >> mlog;
    b    = i & ((1 << mlog) - 1);
    lane = k & (NLANES - 1);
    slot = k >> LANE_LOG;
    return IDX_W'(lane * LANE_BITS + (slot << mlog) + b);
  endfunction

  for (genvar i = 0; i < BEAT_W; i++) begin : g_bit
    assign lin_o[i] = beat_i[src_pos(i, mew_i)];
  end

endmodule

// File: rtl/mstrb_expand.sv
module mstrb_expand
  import mstrb_pkg::*;
#(
  parameter int unsigned NLANES = 4,
  parameter int unsigned CNT_W  = 13
) (
  input  logic [NLANES*LANE_BITS-1:0]  lin_i,
  input  logic [5:0]                   sub_i,
  input  ew_e                          sew_i,
  input  logic [CNT_W-1:0]             base_i,
  input  logic [CNT_W-1:0]             vl_i,
  output logic [NLANES*LANE_BYTES-1:0] strb_o
);

  localparam int unsigned BEAT_W   = NLANES * LANE_BITS;
  localparam int unsigned IDX_W    = $clog2(BEAT_W);
  localparam int unsigned LANE_LOG = $clog2(NLANES);

  // element offset inside the set for lane l, byte y
  function automatic int unsigned elem_in_set(int unsigned l, int unsigned y, ew_e sew);
    return ((y >> ew_log_bytes(sew)) << LANE_LOG) + l;
  endfunction

  // linear bit inside the beat for set sub, element offset q
  function automatic logic [IDX_W-1:0] bit_in_beat(logic [5:0] sub, int unsigned q, ew_e sew);
    int unsigned set_log;
    set_log = LANE_LOG + 3 - ew_log_bytes(sew);
    return IDX_W'((int'(sub) << set_log) + q);
  endfunction

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    for (genvar y = 0; y < LANE_BYTES; y++) begin : g_byte
      logic [CNT_W-1:0] elem_abs;
      logic             in_range;
      always_comb begin
        elem_abs = base_i + CNT_W'(elem_in_set(l, y, sew_i));
        in_range = elem_abs < vl_i;
        strb_o[l*LANE_BYTES + y] = in_range && lin_i[bit_in_beat(sub_i, elem_in_set(l, y, sew_i), sew_i)];
      end
    end
  end

endmodule

// File: rtl/mstrb_fifo.sv
module mstrb_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             full_o,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [WIDTH-1:0] data_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             rd_fire;

  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign valid_o = (count_q != '0);
  assign data_o  = mem_q[rd_ptr_q];
  assign rd_fire = valid_o && ready_i;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_i) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (rd_fire) rd_ptr_q <= ptr_next(rd_ptr_q);
      if (wr_i && !rd_fire) count_q <= count_q + 1'b1;
      else if (!wr_i && rd_fire) count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_i) mem_q[wr_ptr_q] <= data_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |-> !full_o); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(data_o)); // R9

endmodule

// File: rtl/mask_strobe_gen.sv
module mask_strobe_gen
  import mstrb_pkg::*;
#(
  parameter int unsigned NLANES = 4,
  parameter int unsigned VL_W   = 12,
  parameter int unsigned QDEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [VL_W-1:0]              vl_i,
  input  logic [1:0]                   sew_i,
  input  logic [1:0]                   mew_i,
  input  logic                         mask_valid_i,
  input  logic [NLANES*LANE_BITS-1:0]  mask_data_i,
  output logic                         mask_ready_o,
  output logic                         strb_valid_o,
  output logic [NLANES*LANE_BYTES-1:0] strb_data_o,
  input  logic                         strb_ready_i
);

  localparam int unsigned BEAT_W = NLANES * LANE_BITS;
  localparam int unsigned STRB_W = NLANES * LANE_BYTES;
  localparam int unsigned CNT_W  = VL_W + 1;

  // elements covered by one strobe set
  function automatic logic [CNT_W-1:0] elems_per_set(ew_e sew);
    return CNT_W'((NLANES * LANE_BYTES) >> ew_log_bytes(sew));
  endfunction

  // index of the last set a beat can yield
  function automatic logic [5:0] last_set_idx(ew_e sew);
    return 6'(ew_bits(sew) - 1);
  endfunction

  ew_e              cfg_sew_q, cfg_mew_q;
  logic [CNT_W-1:0] cfg_vl_q;
  logic [CNT_W-1:0] elem_cnt_q;
  logic [5:0]       sub_q;

  logic [BEAT_W-1:0] lin_bits;
  logic [STRB_W-1:0] strb_set;
  logic [CNT_W-1:0]  set_elems;
  logic              done, reach_vl, last_sub, push, q_full;

  assign set_elems    = elems_per_set(cfg_sew_q);
  assign done         = elem_cnt_q >= cfg_vl_q;
  assign reach_vl     = (elem_cnt_q + set_elems) >= cfg_vl_q;
  assign last_sub     = (sub_q == last_set_idx(cfg_sew_q)) || reach_vl;
  assign push         = mask_valid_i && !start_i && !done && !q_full;
  assign mask_ready_o = !start_i && (done || (!q_full && last_sub));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_sew_q  <= EW8;
      cfg_mew_q  <= EW8;
      cfg_vl_q   <= '0;
      elem_cnt_q <= '0;
      sub_q      <= '0;
    end else if (start_i) begin
      cfg_sew_q  <= ew_e'(sew_i);
      cfg_mew_q  <= ew_e'(mew_i);
      cfg_vl_q   <= CNT_W'(vl_i);
      elem_cnt_q <= '0;
      sub_q      <= '0;
    end else if (push) begin
      elem_cnt_q <= elem_cnt_q + set_elems;
      sub_q      <= last_sub ? '0 : sub_q + 1'b1;
    end
  end

  mstrb_deshuffle #(
    .NLANES(NLANES)
  ) u_deshuffle (
    .beat_i(mask_data_i),
    .mew_i (cfg_mew_q),
    .lin_o (lin_bits)
  );

  mstrb_expand #(
    .NLANES(NLANES),
    .CNT_W (CNT_W)
  ) u_expand (
    .lin_i (lin_bits),
    .sub_i (sub_q),
    .sew_i (cfg_sew_q),
    .base_i(elem_cnt_q),
    .vl_i  (cfg_vl_q),
    .strb_o(strb_set)
  );

  mstrb_fifo #(
    .WIDTH(STRB_W),
    .DEPTH(QDEPTH)
  ) u_queue (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (push),
    .data_i (strb_set),
    .full_o (q_full),
    .valid_o(strb_valid_o),
    .ready_i(strb_ready_i),
    .data_o (strb_data_o)
  );

  AST_FULL_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    mask_valid_i && q_full && !done |-> !mask_ready_o); // R6
  AST_CNT_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    q_full && !start_i |=> $stable(elem_cnt_q)); // R6
  AST_ACK_CLEARS_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    mask_valid_i && mask_ready_o |=> sub_q == '0); // R5
  AST_SUB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sub_q <= last_set_idx(cfg_sew_q)); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> elem_cnt_q == '0 && sub_q == '0); // R7
  AST_START_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !mask_ready_o); // R7

endmodule

// File: tb/mask_strobe_gen_bench.sv
module mask_strobe_gen_bench;
  localparam int L      = 4;
  localparam int BEAT_W = L * 64;
  localparam int STRB_W = L * 8;
  localparam int MAXBIT = 2048;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [11:0]       vl_i = '0;
  logic [1:0]        sew_i = '0, mew_i = '0;
  logic              mask_valid_i = 1'b0;
  logic [BEAT_W-1:0] mask_data_i = '0;
  logic              mask_ready_o;
  logic              strb_valid_o;
  logic [STRB_W-1:0] strb_data_o;
  logic              strb_ready_i = 1'b0;

  mask_strobe_gen #(.NLANES(L), .VL_W(12), .QDEPTH(4)) u_mask_strobe_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i), .sew_i(sew_i),
    .mew_i(mew_i), .mask_valid_i(mask_valid_i), .mask_data_i(mask_data_i),
    .mask_ready_o(mask_ready_o), .strb_valid_o(strb_valid_o),
    .strb_data_o(strb_data_o), .strb_ready_i(strb_ready_i)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0, beats_acc = 0;
  string cur_tag = "R3";
  logic [STRB_W-1:0] exp_q[$];
  logic [MAXBIT-1:0] lin_bits;
  bit hold_ready = 1'b0;
  bit done_flag = 1'b0;

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as the queue hands out sets
  logic              stall_prev = 1'b0;
  logic [STRB_W-1:0] data_prev = '0;
  always @(negedge clk) if (rst_n) begin
    if (stall_prev) check(strb_valid_o && strb_data_o == data_prev, "R9 hold", strb_data_o, data_prev);
    strb_ready_i = !hold_ready && ($urandom % 4 != 0);
    if (strb_valid_o && strb_ready_i) begin
      if (exp_q.size() == 0) check(1'b0, "R5/R8 unexpected set", strb_data_o, 0);
      else begin
        logic [STRB_W-1:0] e;
        e = exp_q.pop_front();
        check(strb_data_o == e, {cur_tag, " strobe"}, strb_data_o, e);
      end
    end
    stall_prev = strb_valid_o && !strb_ready_i;
    data_prev  = strb_data_o;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic start_instr(int vl, int sew, int mew);
    @(negedge clk);
    start_i = 1'b1; vl_i = 12'(vl); sew_i = 2'(sew); mew_i = 2'(mew);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drive_beat(logic [BEAT_W-1:0] b, output int waited);
    waited = 0;
    mask_valid_i = 1'b1; mask_data_i = b;
    while (!mask_ready_o) begin @(negedge clk); waited++; end
    @(posedge clk);
    beats_acc++;
    @(negedge clk);
    mask_valid_i = 1'b0;
  endtask

  // build beat t from the linear mask bits in the given layout
  function automatic logic [BEAT_W-1:0] make_beat(int t, int mew);
    logic [BEAT_W-1:0] b;
    int mw, epw, k;
    mw = 8 << mew; epw = 64 / mw; b = '0;
    for (int l = 0; l < L; l++)
      for (int s = 0; s < epw; s++)
        for (int x = 0; x < mw; x++) begin
          k = (t * epw + s) * L + l;
          b[l*64 + s*mw + x] = lin_bits[k*mw + x];
        end
    return b;
  endfunction

  task automatic run_instr(int vl, int sew, int mew, int extra, string tag);
    int n, sets, beats, bpe, w;
    cur_tag = tag;
    start_instr(vl, sew, mew);
    n = L * (8 >> sew); bpe = 1 << sew;
    sets = (vl + n - 1) / n;
    beats = (vl + BEAT_W - 1) / BEAT_W;
    lin_bits = '0;
    for (int i = 0; i < (beats + extra) * BEAT_W; i++) lin_bits[i] = 1'($urandom % 2);
    for (int o = 0; o < sets; o++) begin
      logic [STRB_W-1:0] s;
      s = '0;
      for (int q = 0; q < n; q++) begin
        int e;
        e = o * n + q;
        if (e < vl && lin_bits[e])
          for (int k = 0; k < bpe; k++) s[(q % L)*8 + (q / L)*bpe + k] = 1'b1;
      end
      exp_q.push_back(s);
    end
    for (int t = 0; t < beats + extra; t++) begin
      drive_beat(make_beat(t, mew), w);
      if (t >= beats) check(w == 0, "R8 extra beat ack", w, 0);
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    check(!strb_valid_o, {tag, " no surplus set"}, strb_valid_o, 0);
  endtask

  initial begin
    int w, a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!strb_valid_o, "R1 valid after reset", strb_valid_o, 0);
    check(mask_ready_o, "R1 ready after reset", mask_ready_o, 1);
    drive_beat({BEAT_W{1'b1}}, w);
    repeat (4) @(negedge clk);
    check(!strb_valid_o, "R1 beat before start", strb_valid_o, 0);

    // every data width against every layout width, odd lengths (R2 R3 R4 R7)
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 4; m++)
        run_instr(37 + 23 * s + 11 * m, s, m, 0, "R2/R3/R4/R7");
    run_instr(1, 3, 0, 0, "R4 single");
    run_instr(256, 0, 2, 0, "R5 full beat");
    run_instr(301, 2, 1, 0, "R5 two beats");
    run_instr(130, 1, 3, 2, "R8");

    // full queue in the middle of a beat (R6)
    cur_tag = "R6";
    hold_ready = 1'b1;
    start_instr(200, 0, 0);
    lin_bits = '0;
    for (int i = 0; i < BEAT_W; i++) lin_bits[i] = 1'($urandom % 2);
    for (int o = 0; o < 7; o++) begin
      logic [STRB_W-1:0] sx;
      sx = '0;
      for (int q = 0; q < 32; q++)
        if (o * 32 + q < 200 && lin_bits[o*32 + q]) sx[(q % L)*8 + q / L] = 1'b1;
      exp_q.push_back(sx);
    end
    fork
      drive_beat(make_beat(0, 0), w);
      begin
        repeat (12) @(negedge clk);
        a = beats_acc;
        check(strb_valid_o, "R6 queue holds sets", strb_valid_o, 1);
        repeat (10) @(negedge clk);
        check(beats_acc == a, "R6 beat not acked while full", beats_acc, a);
        check(!mask_ready_o, "R6 ready low while full", mask_ready_o, 0);
        hold_ready = 1'b0;
      end
    join
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    check(!strb_valid_o, "R6 no surplus set", strb_valid_o, 0);
    check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule